// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider Controller

This block sits behind a dual-modulus prescaler in a fractional-N synthesizer. It is clocked by the prescaler output. It drives the prescaler's modulus-select line and produces one divider output pulse per divider cycle. Each cycle lasts N = M*P + S input (VCO) periods. P is the prescaler modulus, M is the main count and S is the swallow count: the prescaler divides by P+1 for the first S of its periods and by P for the rest.

A fractional accumulator with a programmable power-of-two modulus adds one extra swallow period on selected cycles. The average ratio is therefore N + F/2^k. F is the numerator and 2^k is the denominator, with 2^k at most 32. Programmed values are captured only at a cycle boundary, so no cycle mixes old and new settings. A sticky flag reports settings that the pulse-swallow structure cannot realise.

The RF configuration uses P = 32 with a 19-bit division word. The IF configuration uses P = 16 with an 18-bit word. Both are chosen by parameters.

Top module: `fnd_divider_ctrl`

## Requirements
- R1: The division word holds S in its low log2(P) bits and M in the remaining upper bits. With a zero numerator, every divider cycle spans exactly M*P + S input periods.
- R2: Within a cycle, `mod_sel` is high (1 = divide by P+1) for the first S + c prescaler periods and low for the rest. Here c is the carry from the accumulator.
- R3: `div_pulse` is high for exactly one prescaler period, the last period of each cycle.
- R4: Over any 2^k consecutive cycles with fixed settings, the total is 2^k*(M*P + S) + F input periods, and each single cycle is either M*P + S or M*P + S + 1 periods.
- R5: `frac_exp` gives k, so the denominator is 2^k. Codes 0 to 5 select 1 to 32, and codes 6 and 7 act as 5. The numerator is used modulo 2^k, so k = 0 is pure integer division.
- R6: A change of `div_word`, `frac_num` or `frac_exp` takes effect from the cycle that starts after the next `div_pulse`. The cycle in progress keeps the old values.
- R7: `cfg_err` goes high when a cycle runs with M = 0, or with S + c greater than M. It stays high until reset.
- R8: Synchronous reset clears the accumulator, the carry and `cfg_err`, and loads the settings. The first cycle after reset therefore adds no extra period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous reset, active high |
| div_word | input | WORD_W | Division word: main count in the upper bits, swallow count in the low log2(P) bits |
| frac_num | input | 5 | Fractional numerator |
| frac_exp | input | 3 | Denominator exponent k |
| mod_sel | output | 1 | Prescaler modulus select, 1 = P+1 |
| div_pulse | output | 1 | Divider output pulse, one prescaler period wide |
| cfg_err | output | 1 | Sticky illegal-setting flag |

## Verification
Three events share one prescaler edge at the end of each cycle: the output pulse, the capture of new settings, and the accumulator step whose carry lengthens the next cycle. The bench provokes this by rewriting the settings partway through a cycle while a fractional setting is active, then switching to an integer one. It then requires the cycle in progress to keep an old length and the following cycles to take the new integer length exactly. A second case makes the carry and the error check meet: it sets S equal to M with a fractional numerator, so the flag must stay low for the carry-free cycles and rise in the first cycle that receives a carry.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
   localparam int FRAC_W  = 5;
   localparam int EXP_W   = 3;
   localparam int MAX_EXP = 5;

   // exponent codes above the largest modulus saturate to it
   function automatic logic [EXP_W-1:0] clamp_exp(input logic [EXP_W-1:0] e);
      return (e > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : e;
   endfunction
endpackage

// File: rtl/fnd_cfg_shadow.sv
module fnd_cfg_shadow
   import fnd_pkg::*;
#(
   parameter int A_W = 5,
   parameter int M_W = 14
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load,
   input  logic [M_W+A_W-1:0]   word_in,
   input  logic [EXP_W-1:0]     exp_in,
   output logic [EXP_W-1:0]     exp_nxt,
   output logic [M_W-1:0]       m_cur,
   output logic [A_W-1:0]       a_cur,
   output logic [EXP_W-1:0]     exp_cur
);
   assign exp_nxt = clamp_exp(exp_in);

   // settings are captured only at a cycle boundary or in reset
   always_ff @(posedge clk) begin
      if (rst || load) begin
         m_cur   <= word_in[M_W+A_W-1:A_W];
         a_cur   <= word_in[A_W-1:0];
         exp_cur <= exp_nxt;
      end
   end
endmodule

// File: rtl/fnd_frac_acc.sv
module fnd_frac_acc
   import fnd_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic [FRAC_W-1:0] num_in,
   input  logic [EXP_W-1:0]  exp_in,
   output logic [FRAC_W-1:0] acc_q,
   output logic              carry_q,
   output logic              carry_nxt
);
   logic [FRAC_W-1:0] mask;
   logic [FRAC_W:0]   sum;
   logic [FRAC_W:0]   modulus;

   for (genvar i = 0; i < FRAC_W; i++) begin : g_mask
      assign mask[i] = (EXP_W'(i) < exp_in);
   end

   assign modulus   = (FRAC_W+1)'(1) << exp_in;
   assign sum       = {1'b0, acc_q & mask} + {1'b0, num_in & mask};
   assign carry_nxt = (sum >= modulus);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q   <= '0;
         carry_q <= 1'b0;
      end else if (step) begin
         acc_q   <= sum[FRAC_W-1:0] & mask;
         carry_q <= carry_nxt;
      end
   end
endmodule

// File: rtl/fnd_swallow_cnt.sv
module fnd_swallow_cnt #(
   parameter int A_W = 5,
   parameter int M_W = 14
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [M_W-1:0] m_cur,
   input  logic [A_W-1:0] a_cur,
   input  logic           carry,
   output logic [M_W-1:0] idx_q,
   output logic           mod_sel,
   output logic           tc
);
   logic [M_W:0] idx_inc;
   logic [A_W:0] a_eff;

   assign idx_inc = {1'b0, idx_q} + (M_W+1)'(1);
   // a main count of zero behaves as one so the cycle still ends
   assign tc      = (idx_inc >= {1'b0, m_cur});
   assign a_eff   = {1'b0, a_cur} + (A_W+1)'(carry);
   assign mod_sel = ({1'b0, idx_q} < (M_W+1)'(a_eff));

   always_ff @(posedge clk) begin
      if (rst || tc) idx_q <= '0;
      else           idx_q <= idx_inc[M_W-1:0];
   end
endmodule

// File: rtl/fnd_divider_ctrl.sv
module fnd_divider_ctrl
   import fnd_pkg::*;
#(
   parameter int PRESCALE = 32,
   parameter int WORD_W   = 19
) (
   input  logic              pclk,
   input  logic              rst,
   input  logic [WORD_W-1:0] div_word,
   input  logic [FRAC_W-1:0] frac_num,
   input  logic [EXP_W-1:0]  frac_exp,
   output logic              mod_sel,
   output logic              div_pulse,
   output logic              cfg_err
);
   localparam int A_W = $clog2(PRESCALE);
   localparam int M_W = WORD_W - A_W;

   if ((PRESCALE < 2) || ((PRESCALE & (PRESCALE - 1)) != 0)) begin : g_bad_p
      $error("PRESCALE must be a power of two");
   end
   if (M_W < A_W) begin : g_bad_w
      $error("WORD_W too small for the prescaler modulus");
   end

   logic [M_W-1:0]    m_cur;
   logic [A_W-1:0]    a_cur;
   logic [EXP_W-1:0]  exp_cur;
   logic [EXP_W-1:0]  exp_nxt;
   logic [FRAC_W-1:0] acc_q;
   logic              carry_q;
   logic              carry_nxt;
   logic [M_W-1:0]    idx_q;
   logic              tc;
   logic              bad_cur;
   logic              err_q;

   fnd_cfg_shadow #(.A_W(A_W), .M_W(M_W)) u_cfg (
      .clk(pclk), .rst(rst), .load(tc),
      .word_in(div_word), .exp_in(frac_exp), .exp_nxt(exp_nxt),
      .m_cur(m_cur), .a_cur(a_cur), .exp_cur(exp_cur)
   );

   fnd_frac_acc u_acc (
      .clk(pclk), .rst(rst), .step(tc),
      .num_in(frac_num), .exp_in(exp_nxt),
      .acc_q(acc_q), .carry_q(carry_q), .carry_nxt(carry_nxt)
   );

   fnd_swallow_cnt #(.A_W(A_W), .M_W(M_W)) u_cnt (
      .clk(pclk), .rst(rst), .m_cur(m_cur), .a_cur(a_cur),
      .carry(carry_q), .idx_q(idx_q), .mod_sel(mod_sel), .tc(tc)
   );

   assign bad_cur = (m_cur == '0) ||
                    (((M_W+1)'(a_cur) + (M_W+1)'(carry_q)) > {1'b0, m_cur});

   always_ff @(posedge pclk) begin
      if (rst)          err_q <= 1'b0;
      else if (bad_cur) err_q <= 1'b1;
   end

   assign div_pulse = tc;
   assign cfg_err   = err_q;
endmodule

// File: rtl/fnd_divider_ctrl_chk.sv
module fnd_divider_ctrl_chk
   import fnd_pkg::*;
#(
   parameter int A_W = 5,
   parameter int M_W = 14
) (
   input logic              clk,
   input logic              rst,
   input logic              div_pulse,
   input logic              mod_sel,
   input logic              cfg_err,
   input logic [M_W-1:0]    idx_q,
   input logic [M_W-1:0]    m_cur,
   input logic [A_W-1:0]    a_cur,
   input logic [FRAC_W-1:0] acc_q,
   input logic [EXP_W-1:0]  exp_cur
);
   a_r3_pulse_one_period: assert property (@(posedge clk) disable iff (rst)
      div_pulse |=> (!div_pulse || (m_cur <= M_W'(1))));

   a_r2_modsel_prefix: assert property (@(posedge clk) disable iff (rst)
      (!mod_sel && !div_pulse) |=> !mod_sel);

   a_r6_cfg_hold: assert property (@(posedge clk) disable iff (rst)
      !div_pulse |=> ($stable(m_cur) && $stable(a_cur) && $stable(exp_cur)));

   a_r5_acc_in_range: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, acc_q} < ((FRAC_W+1)'(1) << exp_cur)));

   a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
      cfg_err |=> cfg_err);

   a_r8_reset_clears: assert property (@(posedge clk)
      rst |=> ((acc_q == '0) && (idx_q == '0) && !cfg_err));
endmodule

bind fnd_divider_ctrl fnd_divider_ctrl_chk #(.A_W(A_W), .M_W(M_W)) u_chk (
   .clk(pclk), .rst(rst), .div_pulse(div_pulse), .mod_sel(mod_sel),
   .cfg_err(cfg_err), .idx_q(idx_q), .m_cur(m_cur), .a_cur(a_cur),
   .acc_q(acc_q), .exp_cur(exp_cur)
);

// File: tb/tb_fnd_divider_ctrl.sv
module tb_fnd_divider_ctrl;
   localparam int P  = 16;
   localparam int WW = 18;
   localparam int AW = 4;
   localparam int NV = 9;
   // {main count, swallow count, numerator, exponent code}
   localparam int VEC [NV][4] = '{
      '{5, 2, 0, 0}, '{6, 3, 1, 1}, '{4, 0, 3, 2}, '{8, 5, 5, 3},
      '{7, 5, 13, 4}, '{9, 1, 31, 5}, '{10, 7, 17, 5},
      '{5, 2, 13, 2}, '{5, 1, 3, 7}
   };

   logic vco = 1'b0;
   always #5 vco = ~vco;

   logic          pclk = 1'b0;
   logic          rst = 1'b1;
   logic [WW-1:0] word = '0;
   logic [4:0]    num = '0;
   logic [2:0]    expo = '0;
   logic          mod_sel, div_pulse, cfg_err;

   fnd_divider_ctrl #(.PRESCALE(P), .WORD_W(WW)) dut (
      .pclk(pclk), .rst(rst), .div_word(word), .frac_num(num),
      .frac_exp(expo), .mod_sel(mod_sel), .div_pulse(div_pulse),
      .cfg_err(cfg_err)
   );

   // dual-modulus prescaler model
   int pc = 0;
   int plen = P;
   always @(posedge vco) begin
      if (pc >= plen - 1) begin
         pc   <= 0;
         pclk <= 1'b1;
      end else begin
         pc   <= pc + 1;
         pclk <= (pc + 1) < (P / 2);
      end
   end
   always @(negedge vco) plen <= (mod_sel === 1'b1) ? P + 1 : P;

   // interval and pulse-width measurement in VCO periods
   int tick = 0, last_rise = 0, last_len = 0, hi_cnt = 0, last_width = 0;
   logic prev = 1'b0;
   event rise_ev;
   always @(negedge vco) begin
      tick++;
      if (div_pulse === 1'b1) hi_cnt++;
      else if (prev) begin
         last_width = hi_cnt;
         hi_cnt = 0;
      end
      if ((div_pulse === 1'b1) && !prev) begin
         last_len  = tick - last_rise;
         last_rise = tick;
         -> rise_ev;
      end
      prev = (div_pulse === 1'b1);
   end

   int checks = 0, fails = 0;
   bit done = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_in(input string tag, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic next_iv(output int len);
      @(rise_ev);
      len = last_len;
   endtask

   task automatic skip_iv(input int n);
      int d;
      for (int i = 0; i < n; i++) next_iv(d);
   endtask

   task automatic apply(input int m, input int a, input int n, input int k);
      @(negedge vco);
      word = WW'((m << AW) | a);
      num  = 5'(n);
      expo = 3'(k);
   endtask

   task automatic after_fall();
      wait (div_pulse === 1'b1);
      wait (div_pulse === 1'b0);
      @(negedge vco);
   endtask

   initial begin
      repeat (200000) @(posedge vco);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int iv, sum, n_int, ke, md, nm;
      string tag;
      // R8: reset state, then first cycles without an extra period
      apply(5, 2, 1, 1);
      rst = 1'b1;
      repeat (300) @(negedge vco);
      chk("R8 cfg_err in reset", int'(cfg_err), 0);
      chk("R8 div_pulse in reset", int'(div_pulse), 0);
      chk("R8 mod_sel in reset", int'(mod_sel), 1);
      rst = 1'b0;
      skip_iv(1);
      next_iv(iv); chk("R8 first interval after reset", iv, 82);
      next_iv(iv); chk("R8 second interval gets carry", iv, 83);

      // vector table: R1, R3, R4, R5
      for (int v = 0; v < NV; v++) begin
         apply(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
         skip_iv(3);
         n_int = VEC[v][0] * P + VEC[v][1];
         ke    = (VEC[v][3] > 5) ? 5 : VEC[v][3];
         md    = 1 << ke;
         nm    = VEC[v][2] % md;
         sum   = 0;
         for (int j = 0; j < md; j++) begin
            next_iv(iv);
            sum += iv;
            chk_in("R4 single interval", iv, n_int, n_int + ((nm != 0) ? 1 : 0));
         end
         if (ke == 0) tag = "R1 integer interval";
         else if ((VEC[v][3] > 5) || (VEC[v][2] >= md)) tag = "R5 exponent/numerator coding";
         else tag = "R4 fractional total";
         chk(tag, sum, md * n_int + nm);
         repeat (2) @(negedge vco);
         chk("R3 pulse width", last_width, P);
      end

      // R2 and R3: modulus select pattern across one cycle, S=3, M=6
      apply(6, 3, 0, 0);
      skip_iv(3);
      after_fall();
      for (int i = 0; i < 6; i++) begin
         chk("R2 mod_sel per period", int'(mod_sel), (i < 3) ? 1 : 0);
         chk("R3 pulse only in last period", int'(div_pulse), (i == 5) ? 1 : 0);
         @(posedge pclk);
         @(negedge vco);
      end

      // R6: change settings mid-cycle while fractional stepping is active
      apply(5, 2, 1, 1);
      skip_iv(3);
      after_fall();
      repeat (3) @(negedge vco);
      word = WW'((6 << AW) | 1);
      num  = 5'd0;
      expo = 3'd0;
      next_iv(iv); chk_in("R6 cycle in progress keeps old setting", iv, 82, 83);
      next_iv(iv); chk("R6 next cycle uses new setting", iv, 97);
      next_iv(iv); chk("R6 new setting persists", iv, 97);

      // R7: swallow count above main count, sticky, cleared by reset
      apply(4, 5, 0, 0);
      skip_iv(2);
      chk("R7 swallow above main count", int'(cfg_err), 1);
      apply(5, 2, 0, 0);
      skip_iv(2);
      chk("R7 flag sticky after legal setting", int'(cfg_err), 1);
      apply(4, 4, 1, 1);
      rst = 1'b1;
      repeat (200) @(negedge vco);
      chk("R7 reset clears flag", int'(cfg_err), 0);
      rst = 1'b0;
      // R7: S equal to M is legal until a carry arrives
      next_iv(iv); chk("R7 S=M without carry, cycle 0", int'(cfg_err), 0);
      next_iv(iv); chk("R7 S=M without carry, cycle 1", int'(cfg_err), 0);
      next_iv(iv); chk("R7 carry pushes swallow above M", int'(cfg_err), 1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule